// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block programs a target FPGA through its byte-wide passive configuration port. A start command, with a total byte count and a secure-mode select, launches a fixed sequence. The block holds the target's active-low configuration reset low for a set time, releases it, and waits for the target to settle. It then takes the image bytes one at a time from a valid/ready stream and clocks each one into the target.

Before each byte the block samples the target's status line, and a low status ends the load at once. After the last byte it gives one extra clock edge, waits a set time and then samples the target's done line. Every interval is written in nanoseconds and converted to system clock cycles from a clock-frequency parameter, so short values can be used in a testbench. The outcome (success, or failure with or without abort) stays on the outputs until the next start. A count of the bytes accepted in the current load is always visible, and it stops changing when the load fails.

Top module: `par_cfg_loader`

## Requirements
- R1: While idle, the configuration reset output is high and the configuration clock is low. A start with a non-zero count drives the configuration reset low for exactly RST_CYC system cycles, where RST_CYC is the reset-hold time in ns converted to cycles and rounded up.
- R2: After the configuration reset is released, at least SETTLE_CYC cycles pass before the first rising edge of the configuration clock.
- R3: Each byte is on the data bus before its first rising clock edge and stays stable through all of its pulses. Every high phase lasts at least PHASE_CYC cycles, and so does every low phase between two pulses.
- R4: With secure low at start, each byte gets exactly one clock pulse. With secure high, each byte gets four. A completed load of N bytes therefore shows N+1 or 4N+1 rising edges, counting the final one.
- R5: If the status input is low when the next byte is due, no further clock edge is produced. Fail and abort go high together. The sent count stays at the number of bytes accepted so far.
- R6: After the last byte's pulses, one more rising edge is produced and the clock then stays high. Done is sampled no sooner than DONE_CYC cycles after that edge. High gives success; low gives fail and abort.
- R7: A start with a byte count of zero gives fail (with abort low) on the next cycle. The configuration reset and the clock do not move.
- R8: Ready is high only while the block is waiting for the next byte and status is high. While valid is low the block waits, with the configuration clock held low.
- R9: Busy is high from the cycle after an accepted start until the load ends. Success and fail stay set until the next start and are never both high.
- R10: After reset: configuration reset high, clock low, and ready, busy, success, fail, abort and count all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a load (accepted when not busy) |
| secure_i | input | 1 | Four clock pulses per byte when high |
| byte_count_i | input | CNT_W | Total bytes in the image |
| in_data_i | input | DATA_W | Image byte |
| in_valid_i | input | 1 | Image byte valid |
| in_ready_o | output | 1 | Block takes a byte this cycle if valid |
| tgt_ok_i | input | 1 | Target status, high when no error |
| tgt_done_i | input | 1 | Target configuration done |
| tgt_rst_n_o | output | 1 | Active-low configuration reset to target |
| tgt_clk_o | output | 1 | Configuration clock to target |
| tgt_data_o | output | DATA_W | Configuration data bus |
| abort_o | output | 1 | Load abandoned on a target error |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Load finished with done high (sticky) |
| fail_o | output | 1 | Load failed or was rejected (sticky) |
| sent_count_o | output | CNT_W | Bytes accepted in the current load |

## Verification
Loads are run in normal and secure mode with one, several and many bytes. The edge counts then separate one pulse per byte from four, and show whether the final extra edge is there. A stalling input stream, with valid low on every third cycle, tests whether the clock stays low while the block waits. Status drops before the first byte and partway through a load, and done reads low, so the count freeze and the abort can be told apart from a clean finish. The done line reads the wrong value until the full wait has passed, so a check made too early gives the wrong result.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RESET_LOW, S_WAIT_FIRST, S_CHECK_STATUS, S_PRESENT,
    S_CLK_HIGH, S_CLK_LOW, S_FINAL_CLK, S_WAIT_DONE, S_DONE_OK, S_FAIL
  } cfgld_state_e;

  // nanoseconds to system cycles, rounded up, never below one
  function automatic int unsigned ns_to_cycles(longint unsigned ns, longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return 32'(c);
  endfunction

  // clock pulses given to each data byte
  function automatic int unsigned pulses_per_byte(logic secure);
    return secure ? 32'd4 : 32'd1;
  endfunction

endpackage

// File: rtl/cfgld_timer.sv
module cfgld_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load_i)     cnt <= val_i;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired_o = (cnt == '0);
endmodule

// File: rtl/cfgld_byte_ctr.sv
module cfgld_byte_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         inc_i,
  input  logic [W-1:0] total_i,
  output logic [W-1:0] count_o,
  output logic         last_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_o <= '0;
    else if (clear_i) count_o <= '0;
    else if (inc_i)   count_o <= count_o + 1'b1;
  end

  assign last_o = (count_o == total_i);
endmodule

// File: rtl/par_cfg_loader.sv
module par_cfg_loader
  import cfgld_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 125_000_000,
  parameter longint unsigned RST_NS    = 5_000,
  parameter longint unsigned SETTLE_NS = 100_000,
  parameter longint unsigned PHASE_NS  = 5,
  parameter longint unsigned DONE_NS   = 100_000,
  parameter int              CNT_W     = 16,
  parameter int              DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              secure_i,
  input  logic [CNT_W-1:0]  byte_count_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              tgt_ok_i,
  input  logic              tgt_done_i,
  output logic              tgt_rst_n_o,
  output logic              tgt_clk_o,
  output logic [DATA_W-1:0] tgt_data_o,
  output logic              abort_o,
  output logic              busy_o,
  output logic              ok_o,
  output logic              fail_o,
  output logic [CNT_W-1:0]  sent_count_o
);
  localparam int unsigned RST_CYC    = ns_to_cycles(RST_NS, CLK_HZ);
  localparam int unsigned SETTLE_CYC = ns_to_cycles(SETTLE_NS, CLK_HZ);
  localparam int unsigned PHASE_CYC  = ns_to_cycles(PHASE_NS, CLK_HZ);
  localparam int unsigned DONE_CYC   = ns_to_cycles(DONE_NS, CLK_HZ);
  localparam int unsigned MAX_A      = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int unsigned MAX_B      = (PHASE_CYC > DONE_CYC) ? PHASE_CYC : DONE_CYC;
  localparam int unsigned MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int          TW         = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] RST_LD    = TW'(RST_CYC - 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] PHASE_LD  = TW'(PHASE_CYC - 1);
  localparam logic [TW-1:0] DONE_LD   = TW'(DONE_CYC - 1);

  cfgld_state_e       state, nxt;
  logic               secure_q;
  logic [CNT_W-1:0]   total_q;
  logic [DATA_W-1:0]  data_q;
  logic [1:0]         pulses_left;
  logic               abort_q;

  // named internal events
  logic               start_go, byte_accept, status_err, done_good, done_bad;
  logic               tmr_load, tmr_expired, last_byte, extra_pulse;
  logic [TW-1:0]      tmr_val;

  assign start_go    = start_i && (state == S_IDLE || state == S_DONE_OK || state == S_FAIL);
  assign in_ready_o  = (state == S_CHECK_STATUS) && tgt_ok_i;
  assign byte_accept = in_ready_o && in_valid_i;
  assign status_err  = (state == S_CHECK_STATUS) && !tgt_ok_i;
  assign done_good   = (state == S_WAIT_DONE) && tmr_expired && tgt_done_i;
  assign done_bad    = (state == S_WAIT_DONE) && tmr_expired && !tgt_done_i;
  assign extra_pulse = (state == S_CLK_LOW) && tmr_expired && (pulses_left != 2'd0);

  cfgld_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .expired_o(tmr_expired)
  );

  cfgld_byte_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear_i(start_go), .inc_i(byte_accept),
    .total_i(total_q), .count_o(sent_count_o), .last_o(last_byte)
  );

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      S_IDLE, S_DONE_OK, S_FAIL: begin
        if (start_i) begin
          if (byte_count_i == '0) nxt = S_FAIL;
          else begin nxt = S_RESET_LOW; tmr_load = 1'b1; tmr_val = RST_LD; end
        end
      end
      S_RESET_LOW: if (tmr_expired) begin
        nxt = S_WAIT_FIRST; tmr_load = 1'b1; tmr_val = SETTLE_LD;
      end
      S_WAIT_FIRST: if (tmr_expired) nxt = S_CHECK_STATUS;
      S_CHECK_STATUS: begin
        if (status_err) nxt = S_FAIL;
        else if (byte_accept) begin nxt = S_PRESENT; tmr_load = 1'b1; tmr_val = PHASE_LD; end
      end
      S_PRESENT: if (tmr_expired) begin
        nxt = S_CLK_HIGH; tmr_load = 1'b1; tmr_val = PHASE_LD;
      end
      S_CLK_HIGH: if (tmr_expired) begin
        nxt = S_CLK_LOW; tmr_load = 1'b1; tmr_val = PHASE_LD;
      end
      S_CLK_LOW: if (tmr_expired) begin
        if (pulses_left != 2'd0) begin nxt = S_CLK_HIGH; tmr_load = 1'b1; tmr_val = PHASE_LD; end
        else if (last_byte)      begin nxt = S_FINAL_CLK; tmr_load = 1'b1; tmr_val = PHASE_LD; end
        else nxt = S_CHECK_STATUS;
      end
      S_FINAL_CLK: if (tmr_expired) begin
        nxt = S_WAIT_DONE; tmr_load = 1'b1; tmr_val = DONE_LD;
      end
      S_WAIT_DONE: if (tmr_expired) nxt = tgt_done_i ? S_DONE_OK : S_FAIL;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      secure_q    <= 1'b0;
      total_q     <= '0;
      data_q      <= '0;
      pulses_left <= 2'd0;
      abort_q     <= 1'b0;
    end else begin
      state <= nxt;
      if (start_go) begin
        secure_q <= secure_i;
        total_q  <= byte_count_i;
      end
      if (byte_accept) begin
        data_q      <= in_data_i;
        pulses_left <= 2'(pulses_per_byte(secure_q) - 1);
      end else if (extra_pulse) begin
        pulses_left <= pulses_left - 2'd1;
      end
      if (start_go)                    abort_q <= 1'b0;
      else if (status_err || done_bad) abort_q <= 1'b1;
    end
  end

  assign tgt_rst_n_o = (state != S_RESET_LOW);
  assign tgt_clk_o   = (state == S_CLK_HIGH) || (state == S_FINAL_CLK) || (state == S_WAIT_DONE);
  assign tgt_data_o  = data_q;
  assign abort_o     = abort_q;
  assign ok_o        = (state == S_DONE_OK);
  assign fail_o      = (state == S_FAIL);
  assign busy_o      = !(state == S_IDLE || state == S_DONE_OK || state == S_FAIL);

  // ---------------- assertions ----------------
  localparam int PW = $clog2(PHASE_CYC + 2) + 1;
  logic          clk_d;
  logic [PW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d   <= 1'b0;
      run_len <= '0;
    end else begin
      clk_d <= tgt_clk_o;
      if (tgt_clk_o != clk_d)  run_len <= PW'(1);
      else if (run_len != '1)  run_len <= run_len + 1'b1;
    end
  end

  p_phase_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_clk_o != clk_d) |-> (run_len >= PW'(PHASE_CYC)));
  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_clk_o && !byte_accept) |=> $stable(tgt_data_o));
  p_status_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status_err |=> (fail_o && abort_o && !tgt_clk_o));
  p_frozen_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_i) |=> $stable(sent_count_o));
  p_done_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_bad |=> (fail_o && abort_o));
  p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_go && byte_count_i == '0) |=> (fail_o && !abort_o && tgt_rst_n_o && !tgt_clk_o));
  p_ready_clk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> !tgt_clk_o);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_o && fail_o) && !(busy_o && (ok_o || fail_o)));
  p_ok_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_o && !start_i) |=> ok_o);
  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_i) |=> fail_o);
endmodule

// File: tb/par_cfg_loader_test.sv
module par_cfg_loader_test;
  localparam int CNT_W = 16;
  localparam int RST_NS = 40, SET_NS = 80, PH_NS = 16, DN_NS = 80;

  function automatic int cyc125(int ns);
    return (ns * 125 + 999) / 1000;
  endfunction
  localparam int RST_C = cyc125(RST_NS);
  localparam int SET_C = cyc125(SET_NS);
  localparam int PH_C  = cyc125(PH_NS);
  localparam int DN_C  = cyc125(DN_NS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, secure_i = 0, in_valid_i = 0, tgt_ok_i = 1, tgt_done_i = 0;
  logic [CNT_W-1:0] byte_count_i = '0;
  logic [7:0] in_data_i = '0;
  logic in_ready_o, tgt_rst_n_o, tgt_clk_o, abort_o, busy_o, ok_o, fail_o;
  logic [7:0] tgt_data_o;
  logic [CNT_W-1:0] sent_count_o;

  always #4 clk = ~clk;

  par_cfg_loader #(
    .CLK_HZ(125_000_000), .RST_NS(RST_NS), .SETTLE_NS(SET_NS), .PHASE_NS(PH_NS),
    .DONE_NS(DN_NS), .CNT_W(CNT_W), .DATA_W(8)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .secure_i(secure_i),
    .byte_count_i(byte_count_i), .in_data_i(in_data_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .tgt_ok_i(tgt_ok_i), .tgt_done_i(tgt_done_i),
    .tgt_rst_n_o(tgt_rst_n_o), .tgt_clk_o(tgt_clk_o), .tgt_data_o(tgt_data_o),
    .abort_o(abort_o), .busy_o(busy_o), .ok_o(ok_o), .fail_o(fail_o),
    .sent_count_o(sent_count_o)
  );

  int errors = 0, checks = 0;

  task automatic check(input bit cond, input string req, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int k);
    return 8'h5A ^ 8'(k * 37);
  endfunction

  // sec, bytes, status-fail index (FF = never), done level, stall
  typedef struct packed {
    logic       sec;
    logic [7:0] n;
    logic [7:0] fail_at;
    logic       done;
    logic       stall;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b0, 8'd4, 8'hFF, 1'b1, 1'b0},
    '{1'b1, 8'd3, 8'hFF, 1'b1, 1'b0},
    '{1'b0, 8'd1, 8'hFF, 1'b1, 1'b0},
    '{1'b0, 8'd5, 8'd2,  1'b1, 1'b0},
    '{1'b1, 8'd4, 8'd0,  1'b1, 1'b0},
    '{1'b0, 8'd3, 8'hFF, 1'b0, 1'b0},
    '{1'b1, 8'd2, 8'hFF, 1'b0, 1'b0},
    '{1'b0, 8'd6, 8'hFF, 1'b1, 1'b1}
  };

  task automatic run_vec(input vec_t v, input int id);
    int ppb, accepted, edges, data_bad, rst_low, gap, min_hi, min_lo, run, extra, since_final, r8_bad;
    bit prev_clk, prev_rst, released, first_edge, fin, prev_hs, final_seen, busy_seen;
    bit exp_ok;
    int exp_cnt, exp_edges;
    ppb = v.sec ? 4 : 1;
    accepted = 0; edges = 0; data_bad = 0; rst_low = 0; gap = 0;
    min_hi = 9999; min_lo = 9999; run = 0; extra = 0; since_final = 0; r8_bad = 0;
    prev_clk = 0; prev_rst = 1; released = 0; first_edge = 0; fin = 0; prev_hs = 0;
    final_seen = 0;
    @(negedge clk);
    secure_i = v.sec; byte_count_i = CNT_W'(v.n); start_i = 1'b1;
    tgt_done_i = !v.done; tgt_ok_i = (v.fail_at != 8'd0);
    in_valid_i = 1'b1; in_data_i = pat(0);
    @(negedge clk);
    start_i = 1'b0;
    busy_seen = busy_o;
    for (int t = 0; t < 5000; t++) begin
      if (!tgt_rst_n_o) rst_low++;
      if (tgt_rst_n_o && !prev_rst) released = 1;
      if (released && !first_edge && !tgt_clk_o) gap++;
      if (in_ready_o && tgt_clk_o) r8_bad++;
      if (tgt_clk_o == prev_clk) run++;
      else begin
        if (prev_clk) begin if (run < min_hi) min_hi = run; end
        else if (edges > 0) begin if (run < min_lo) min_lo = run; end
        run = 1;
      end
      if (tgt_clk_o && !prev_clk) begin
        edges++;
        first_edge = 1;
        if ((edges - 1) / ppb < int'(v.n) && tgt_data_o != pat((edges - 1) / ppb)) data_bad++;
        if (edges == int'(v.n) * ppb + 1) final_seen = 1;
      end
      if (final_seen) since_final++;
      prev_clk = tgt_clk_o; prev_rst = tgt_rst_n_o;
      if (prev_hs) accepted++;
      if (fin) begin extra++; if (extra == 6) break; end
      if (ok_o || fail_o) fin = 1;
      in_data_i  = pat(accepted);
      tgt_ok_i   = !(v.fail_at != 8'hFF && accepted >= int'(v.fail_at));
      in_valid_i = v.stall ? (t % 3 != 0) : 1'b1;
      tgt_done_i = (final_seen && since_final > DN_C) ? v.done : !v.done;
      #1 prev_hs = in_valid_i && in_ready_o;
      @(negedge clk);
    end
    exp_ok    = (v.fail_at == 8'hFF) && v.done;
    exp_cnt   = (v.fail_at == 8'hFF) ? int'(v.n) : int'(v.fail_at);
    exp_edges = (v.fail_at == 8'hFF) ? int'(v.n) * ppb + 1 : int'(v.fail_at) * ppb;
    $display("vector %0d: secure=%0d bytes=%0d", id, v.sec, v.n);
    check(busy_seen == 1'b1, "R9", "busy after start", int'(busy_seen), 1);
    check(ok_o == exp_ok, (v.fail_at == 8'hFF) ? "R6" : "R5", "success flag", int'(ok_o), int'(exp_ok));
    check(fail_o == !exp_ok, "R9", "fail flag held", int'(fail_o), int'(!exp_ok));
    check(abort_o == !exp_ok, (v.fail_at == 8'hFF) ? "R6" : "R5", "abort", int'(abort_o), int'(!exp_ok));
    check(int'(sent_count_o) == exp_cnt, "R5", "sent count", int'(sent_count_o), exp_cnt);
    check(edges == exp_edges, "R4", "rising edges", edges, exp_edges);
    check(rst_low == RST_C, "R1", "config reset low cycles", rst_low, RST_C);
    check(data_bad == 0, "R3", "bytes wrong at rising edge", data_bad, 0);
    check(r8_bad == 0, "R8", "clock high while ready", r8_bad, 0);
    if (edges > 0) begin
      check(gap >= SET_C, "R2", "settle before first edge", gap, SET_C);
      check(min_hi >= PH_C, "R3", "min high phase", min_hi, PH_C);
    end
    if (edges > 1) check(min_lo >= PH_C, "R3", "min low phase", min_lo, PH_C);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(tgt_rst_n_o == 1'b1, "R10", "config reset in reset", int'(tgt_rst_n_o), 1);
    check(tgt_clk_o == 1'b0, "R10", "clock in reset", int'(tgt_clk_o), 0);
    check({busy_o, ok_o, fail_o, abort_o, in_ready_o} == 5'b0, "R10", "flags in reset",
          int'({busy_o, ok_o, fail_o, abort_o, in_ready_o}), 0);
    check(sent_count_o == '0, "R10", "count in reset", int'(sent_count_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tgt_rst_n_o && !tgt_clk_o, "R1", "idle pins", int'({tgt_rst_n_o, tgt_clk_o}), 2);

    foreach (VECS[i]) run_vec(VECS[i], i);

    // R7 zero byte count after a successful load
    run_vec(VECS[0], 8);
    @(negedge clk);
    byte_count_i = '0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(fail_o == 1'b1, "R7", "zero count fails", int'(fail_o), 1);
    check(abort_o == 1'b0, "R7", "zero count no abort", int'(abort_o), 0);
    check(ok_o == 1'b0, "R7", "zero count clears success", int'(ok_o), 0);
    begin
      int moved;
      moved = 0;
      for (int k = 0; k < 20; k++) begin
        if (!tgt_rst_n_o || tgt_clk_o || busy_o) moved++;
        @(negedge clk);
      end
      check(moved == 0, "R7", "pins untouched", moved, 0);
    end
    check(fail_o == 1'b1, "R9", "fail sticky", int'(fail_o), 1);
    check(sent_count_o == '0, "R7", "count after zero start", int'(sent_count_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule